// File: doc/BRIEF.md
# Core-Voltage Command Target with Pin-Select Override

This block sits between a host's two-wire bus and the digital control side of a core-voltage regulator. The host addresses it as a bus target and sends a single command byte carrying a 4-bit voltage code and a 2-bit slew code. The block holds both in one command register and presents them to the regulator controller. The host can read the register back with a one-byte read.

A mode input chooses where the voltage code comes from. In bus mode the code comes from the command register. In pin mode the code comes from four external select pins. The two lowest of these pins are the same wires as the bus clock and data lines, so in pin mode the bus engine is held idle and never pulls the data line low. A regulator-enable input gates the outputs to zero while it is low. The command register keeps its contents through that time, so the previous setting returns as soon as the enable comes back.

The bus lines are brought into the system clock domain through a synchronizer. Start and stop conditions are found from data-line edges while the clock line is high. A debug output gives the selected setpoint in millivolts.

Top module: `vcmd_i2c_target`

## Requirements
- R1: The target answers only to 7-bit address 0x0C (address byte 0x18 for a write, 0x19 for a read) by pulling the data line low in the ACK slot. Any other address gets no ACK, and the block ignores the bus, with no ACK on later bytes, until the next START.
- R2: A write carries one command byte. Its bits 3..0 become the voltage code and bits 5..4 become the slew code. Bits 7..6 have no effect. Any byte after the first in the same write is not acknowledged.
- R3: A read returns one byte equal to {2'b00, slew code, voltage code}, driven most significant bit first. The master ends the read with a NACK.
- R4: While enabled, the millivolt output equals 850 + 50 × voltage code: 850 at code 0 and 1600 at code 15.
- R5: With the mode input high, the voltage code is {pin3, pin2, data line, clock line}. The data line is never driven, and bus traffic leaves the command register unchanged.
- R6: With the regulator enable low, the on flag, both code outputs and the millivolt output read 0. Raising the enable again restores the stored codes without a new write.
- R7: A STOP that arrives before the eighth bit of the command byte leaves the register unchanged. The register loads all of its fields at once when the command byte's ACK begins.
- R8: After reset the register holds voltage code 0 and slew code 0, and the data line is released.
- R9: Writes and reads work with bus clock half-periods of 1.25 µs (fast rate) and 5 µs (standard rate).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line; select pin 0 in pin mode |
| sda_i | input | 1 | Bus data line as seen on the wire; select pin 1 in pin mode |
| sda_oe_o | output | 1 | High pulls the data line low (open-drain drive) |
| pin_mode_i | input | 1 | 1 selects the voltage code from pins, 0 from the register |
| vid_hi_i | input | VCODE_W-2 | Upper select pins (pin 3 down to pin 2) |
| reg_en_i | input | 1 | Regulator enable; low forces outputs off |
| volt_code_o | output | VCODE_W | Active voltage code |
| slew_code_o | output | SLEW_W | Active slew code |
| out_on_o | output | 1 | Outputs valid / regulator on |
| mv_o | output | MV_W | Debug setpoint in millivolts |

## Verification
The hardest case to reach is a write that is cut short partway through the command byte, after the address has been acknowledged. At that point the shift register holds a partial value that must never reach the command register. The bench drives the address and five data bits by hand and then issues a STOP from the low phase of the clock. It then reads the register back to confirm that the earlier contents survived. The pin-mode case is also awkward, because the same two wires must carry a complete, legal-looking write that the target must ignore. The bench sends a full write to the target's own address while in pin mode, and then checks both the sampled ACK slots and the register read back after returning to bus mode.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK,
      ST_IGNORE
   } bus_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/vcmd_sync.sv
module vcmd_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= async_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= {chain_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/vcmd_i2c_fsm.sv
module vcmd_i2c_fsm import vcmd_pkg::*; #(
   parameter logic [BYTE_W-2:0] TARGET_ADDR = 7'h0C,
   parameter int unsigned       FIELD_W     = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hold_i,
   input  logic               scl_s_i,
   input  logic               sda_s_i,
   input  logic [BYTE_W-1:0]  rd_data_i,
   output logic               sda_oe_o,
   output logic               wr_commit_o,
   output logic [FIELD_W-1:0] wr_field_o,
   output bus_state_e         state_o
);

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   bus_state_e        state_q;
   logic              scl_q, sda_q;
   logic [BYTE_W-1:0] shreg_q;
   logic [BYTE_W-2:0] tx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              rw_q;
   logic              oe_q;
   logic              commit_q;

   logic scl_rise, scl_fall, start_det, stop_det;

   assign scl_rise  = scl_s_i & ~scl_q;
   assign scl_fall  = ~scl_s_i & scl_q;
   assign start_det = scl_s_i & scl_q & sda_q & ~sda_s_i;
   assign stop_det  = scl_s_i & scl_q & ~sda_q & sda_s_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         shreg_q  <= '0;
         tx_q     <= '0;
         cnt_q    <= '0;
         rw_q     <= 1'b0;
         oe_q     <= 1'b0;
         commit_q <= 1'b0;
      end else begin
         scl_q    <= scl_s_i;
         sda_q    <= sda_s_i;
         commit_q <= 1'b0;
         if (hold_i) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else if (start_det) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg_q <= {shreg_q[BYTE_W-2:0], sda_s_i};
                     cnt_q   <= cnt_q + CNT_W'(1);
                  end else if (scl_fall && cnt_q == LAST_BIT) begin
                     if (shreg_q[BYTE_W-1:1] == TARGET_ADDR) begin
                        rw_q    <= shreg_q[0];
                        oe_q    <= 1'b1;
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        tx_q    <= rd_data_i[BYTE_W-2:0];
                        oe_q    <= ~rd_data_i[BYTE_W-1];
                        state_q <= ST_RDATA;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_WDATA;
                     end
                  end
               end
               ST_WDATA: begin
                  if (scl_rise) begin
                     shreg_q <= {shreg_q[BYTE_W-2:0], sda_s_i};
                     cnt_q   <= cnt_q + CNT_W'(1);
                  end else if (scl_fall && cnt_q == LAST_BIT) begin
                     oe_q     <= 1'b1;
                     commit_q <= 1'b1;
                     state_q  <= ST_WDATA_ACK;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_IGNORE;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end else if (scl_fall) begin
                     if (cnt_q == LAST_BIT) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_RDATA_ACK;
                     end else begin
                        oe_q <= ~tx_q[BYTE_W-2];
                        tx_q <= {tx_q[BYTE_W-3:0], 1'b0};
                     end
                  end
               end
               ST_RDATA_ACK: begin
                  if (scl_rise) state_q <= ST_IGNORE;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign wr_commit_o = commit_q;
   assign wr_field_o  = shreg_q[FIELD_W-1:0];
   assign state_o     = state_q;

endmodule

// File: rtl/vcmd_cmd_reg.sv
module vcmd_cmd_reg import vcmd_pkg::*; #(
   parameter int unsigned VCODE_W = 4,
   parameter int unsigned SLEW_W  = 2
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_commit_i,
   input  logic [VCODE_W+SLEW_W-1:0] wr_field_i,
   output logic [VCODE_W-1:0]        volt_o,
   output logic [SLEW_W-1:0]         slew_o,
   output logic [BYTE_W-1:0]         rd_byte_o
);

   localparam int unsigned FIELD_W = VCODE_W + SLEW_W;

   logic [FIELD_W-1:0] cmd_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmd_q <= '0;
      else if (wr_commit_i) cmd_q <= wr_field_i;
   end

   assign volt_o = cmd_q[VCODE_W-1:0];
   assign slew_o = cmd_q[FIELD_W-1:VCODE_W];

   generate
      if (FIELD_W < BYTE_W) begin : g_pad
         assign rd_byte_o = {{(BYTE_W - FIELD_W){1'b0}}, cmd_q};
      end else begin : g_full
         assign rd_byte_o = cmd_q;
      end
   endgenerate

endmodule

// File: rtl/vcmd_out.sv
module vcmd_out #(
   parameter int unsigned VCODE_W = 4,
   parameter int unsigned SLEW_W  = 2,
   parameter int unsigned MV_W    = 16,
   parameter int unsigned MV_BASE = 850,
   parameter int unsigned MV_STEP = 50
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               pin_mode_i,
   input  logic               reg_en_i,
   input  logic [VCODE_W-1:0] pin_code_i,
   input  logic [VCODE_W-1:0] reg_volt_i,
   input  logic [SLEW_W-1:0]  reg_slew_i,
   output logic [VCODE_W-1:0] volt_o,
   output logic [SLEW_W-1:0]  slew_o,
   output logic               on_o,
   output logic [MV_W-1:0]    mv_o
);

   logic [VCODE_W-1:0] code_sel;
   logic [MV_W-1:0]    mv_calc;

   always_comb begin
      code_sel = pin_mode_i ? pin_code_i : reg_volt_i;
      mv_calc  = MV_W'(MV_BASE) + MV_W'(code_sel) * MV_W'(MV_STEP);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         volt_o <= '0;
         slew_o <= '0;
         on_o   <= 1'b0;
         mv_o   <= '0;
      end else if (reg_en_i) begin
         volt_o <= code_sel;
         slew_o <= reg_slew_i;
         on_o   <= 1'b1;
         mv_o   <= mv_calc;
      end else begin
         volt_o <= '0;
         slew_o <= '0;
         on_o   <= 1'b0;
         mv_o   <= '0;
      end
   end

endmodule

// File: rtl/vcmd_i2c_target.sv
module vcmd_i2c_target import vcmd_pkg::*; #(
   parameter logic [6:0]  TARGET_ADDR = 7'h0C,
   parameter int unsigned VCODE_W     = 4,
   parameter int unsigned SLEW_W      = 2,
   parameter int unsigned MV_W        = 16,
   parameter int unsigned MV_BASE     = 850,
   parameter int unsigned MV_STEP     = 50,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe_o,
   input  logic               pin_mode_i,
   input  logic [VCODE_W-3:0] vid_hi_i,
   input  logic               reg_en_i,
   output logic [VCODE_W-1:0] volt_code_o,
   output logic [SLEW_W-1:0]  slew_code_o,
   output logic               out_on_o,
   output logic [MV_W-1:0]    mv_o
);

   localparam int unsigned FIELD_W = VCODE_W + SLEW_W;
   localparam longint MV_MAX = longint'(MV_BASE) + (longint'(1) << VCODE_W) * longint'(MV_STEP) - longint'(MV_STEP);

   generate
      if (VCODE_W < 3 || FIELD_W > BYTE_W) begin : g_bad_fields
         $error("vcmd_i2c_target: code fields do not fit the command byte");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("vcmd_i2c_target: at least two synchronizer stages required");
      end
      if (MV_MAX >= (longint'(1) << MV_W)) begin : g_bad_mv
         $error("vcmd_i2c_target: millivolt output too narrow");
      end
   endgenerate

   logic [VCODE_W-1:0] pin_s;
   logic               wr_commit;
   logic [FIELD_W-1:0] wr_field;
   logic [VCODE_W-1:0] reg_volt;
   logic [SLEW_W-1:0]  reg_slew;
   logic [BYTE_W-1:0]  rd_byte;
   bus_state_e         bus_state;

   vcmd_sync #(
      .WIDTH  (VCODE_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i ({vid_hi_i, sda_i, scl_i}),
      .sync_o  (pin_s)
   );

   vcmd_i2c_fsm #(
      .TARGET_ADDR (TARGET_ADDR),
      .FIELD_W     (FIELD_W)
   ) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hold_i      (pin_mode_i),
      .scl_s_i     (pin_s[0]),
      .sda_s_i     (pin_s[1]),
      .rd_data_i   (rd_byte),
      .sda_oe_o    (sda_oe_o),
      .wr_commit_o (wr_commit),
      .wr_field_o  (wr_field),
      .state_o     (bus_state)
   );

   vcmd_cmd_reg #(
      .VCODE_W (VCODE_W),
      .SLEW_W  (SLEW_W)
   ) u_reg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_commit_i (wr_commit),
      .wr_field_i  (wr_field),
      .volt_o      (reg_volt),
      .slew_o      (reg_slew),
      .rd_byte_o   (rd_byte)
   );

   vcmd_out #(
      .VCODE_W (VCODE_W),
      .SLEW_W  (SLEW_W),
      .MV_W    (MV_W),
      .MV_BASE (MV_BASE),
      .MV_STEP (MV_STEP)
   ) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_mode_i (pin_mode_i),
      .reg_en_i   (reg_en_i),
      .pin_code_i (pin_s),
      .reg_volt_i (reg_volt),
      .reg_slew_i (reg_slew),
      .volt_o     (volt_code_o),
      .slew_o     (slew_code_o),
      .on_o       (out_on_o),
      .mv_o       (mv_o)
   );

endmodule

// File: rtl/vcmd_chk.sv
module vcmd_chk import vcmd_pkg::*; #(
   parameter int unsigned VCODE_W = 4,
   parameter int unsigned SLEW_W  = 2,
   parameter int unsigned MV_W    = 16,
   parameter int unsigned MV_BASE = 850,
   parameter int unsigned MV_STEP = 50
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               pin_mode_i,
   input logic               reg_en_i,
   input logic               sda_oe_o,
   input logic               out_on_o,
   input logic [VCODE_W-1:0] volt_code_o,
   input logic [SLEW_W-1:0]  slew_code_o,
   input logic [MV_W-1:0]    mv_o,
   input bus_state_e         state_i,
   input logic               wr_commit_i
);

   localparam logic [MV_W-1:0] MV_LO = MV_W'(MV_BASE);
   localparam logic [MV_W-1:0] MV_HI = MV_W'(MV_BASE + ((1 << VCODE_W) - 1) * MV_STEP);

   AST_ACK_ONLY_IN_DRIVE_STATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sda_oe_o |-> (state_i == ST_ADDR_ACK || state_i == ST_WDATA_ACK || state_i == ST_RDATA)); // R1

   AST_MV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_on_o |-> (mv_o >= MV_LO && mv_o <= MV_HI)); // R4

   AST_PIN_MODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_mode_i && $past(pin_mode_i)) |-> (!sda_oe_o && state_i == ST_IDLE)); // R5

   AST_OFF_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_en_i && $past(!reg_en_i)) |-> (!out_on_o && volt_code_o == '0 && slew_code_o == '0 && mv_o == '0)); // R6

   AST_SLEW_CHANGE_NEEDS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_on_o && $past(out_on_o) && slew_code_o != $past(slew_code_o)) |-> $past(wr_commit_i, 2)); // R7

endmodule

bind vcmd_i2c_target vcmd_chk #(
   .VCODE_W (VCODE_W),
   .SLEW_W  (SLEW_W),
   .MV_W    (MV_W),
   .MV_BASE (MV_BASE),
   .MV_STEP (MV_STEP)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pin_mode_i  (pin_mode_i),
   .reg_en_i    (reg_en_i),
   .sda_oe_o    (sda_oe_o),
   .out_on_o    (out_on_o),
   .volt_code_o (volt_code_o),
   .slew_code_o (slew_code_o),
   .mv_o        (mv_o),
   .state_i     (bus_state),
   .wr_commit_i (wr_commit)
);

// File: tb/vcmd_i2c_target_tb.sv
module vcmd_i2c_target_tb;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        scl_m, sda_m, pin_mode, reg_en;
   logic [1:0]  vid_hi;
   logic        sda_oe;
   logic [3:0]  volt;
   logic [1:0]  slew;
   logic        on;
   logic [15:0] mv;
   logic        sda_line;

   int n_chk  = 0;
   int n_fail = 0;
   int half   = 125;
   bit oe_in_pin = 1'b0;

   assign sda_line = sda_m & ~sda_oe;

   vcmd_i2c_target u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe_o    (sda_oe),
      .pin_mode_i  (pin_mode),
      .vid_hi_i    (vid_hi),
      .reg_en_i    (reg_en),
      .volt_code_o (volt),
      .slew_code_o (slew),
      .out_on_o    (on),
      .mv_o        (mv)
   );

   always @(negedge clk) if (pin_mode && sda_oe) oe_in_pin = 1'b1;

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl_m = 1'b1; wait_clk(half);
      sda_m = 1'b0; wait_clk(half);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wait_clk(half / 2); sda_m = 1'b0;
      wait_clk(half / 2); scl_m = 1'b1;
      wait_clk(half);     sda_m = 1'b1;
      wait_clk(half);
   endtask

   task automatic put_bit(input bit b);
      wait_clk(half / 2); sda_m = b;
      wait_clk(half / 2); scl_m = 1'b1;
      wait_clk(half);     scl_m = 1'b0;
   endtask

   task automatic get_bit(output bit b);
      wait_clk(half / 2); sda_m = 1'b1;
      wait_clk(half / 2); scl_m = 1'b1;
      wait_clk(half / 2); b = sda_line;
      wait_clk(half / 2); scl_m = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] d, output bit ack);
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(ack);
   endtask

   task automatic do_write(input logic [6:0] addr, input logic [7:0] d, output bit aa, output bit da);
      bus_start();
      put_byte({addr, 1'b0}, aa);
      put_byte(d, da);
      bus_stop();
   endtask

   task automatic do_read(output bit aa, output logic [7:0] d);
      bit b;
      bus_start();
      put_byte({7'h0C, 1'b1}, aa);
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(1'b1);
      bus_stop();
   endtask

   task automatic check_out(input string req, input int v, input int s, input int m);
      wait_clk(20);
      check({req, " volt"}, int'(volt), v);
      check({req, " slew"}, int'(slew), s);
      check({req, " mv"}, int'(mv), m);
   endtask

   task automatic t_reset();
      check("R8 sda_oe", int'(sda_oe), 0);
      check("R8 on", int'(on), 1);
      check_out("R8", 0, 0, 850);
   endtask

   task automatic t_write_read(input string req, input logic [7:0] d, input int v, input int s);
      bit aa, da;
      logic [7:0] rd;
      do_write(7'h0C, d, aa, da);
      check({req, " R1 addr ack"}, int'(aa), 0);
      check({req, " R1 data ack"}, int'(da), 0);
      check_out({req, " R2"}, v, s, 850 + 50 * v);
      do_read(aa, rd);
      check({req, " R3 read ack"}, int'(aa), 0);
      check({req, " R3 read byte"}, int'(rd), (s << 4) | v);
   endtask

   task automatic t_extra_byte();
      bit aa, da, xa;
      bus_start();
      put_byte({7'h0C, 1'b0}, aa);
      put_byte(8'h12, da);
      put_byte(8'h3D, xa);
      bus_stop();
      check("R2 extra byte nack", int'(xa), 1);
      check_out("R2 extra byte no effect", 2, 1, 950);
   endtask

   task automatic t_mismatch();
      bit aa, da;
      logic [7:0] rd;
      do_write(7'h0D, 8'h15, aa, da);
      check("R1 wrong addr nack", int'(aa), 1);
      check("R1 ignored data nack", int'(da), 1);
      check_out("R1 wrong addr no effect", 0, 3, 850);
      do_read(aa, rd);
      check("R1 listens after start", int'(rd), 8'h30);
   endtask

   task automatic t_abort();
      bit aa;
      logic [7:0] rd;
      bus_start();
      put_byte({7'h0C, 1'b0}, aa);
      for (int i = 0; i < 5; i++) put_bit(1'b1);
      bus_stop();
      check("R7 abort addr ack", int'(aa), 0);
      check_out("R7 abort keeps reg", 0, 3, 850);
      do_read(aa, rd);
      check("R7 abort read back", int'(rd), 8'h30);
   endtask

   task automatic t_disable();
      bit aa, da;
      do_write(7'h0C, 8'h1B, aa, da);
      check_out("R6 before off", 11, 1, 1400);
      reg_en = 1'b0;
      wait_clk(5);
      check("R6 off flag", int'(on), 0);
      check_out("R6 off", 0, 0, 0);
      reg_en = 1'b1;
      wait_clk(5);
      check("R6 on flag", int'(on), 1);
      check_out("R6 restored", 11, 1, 1400);
   endtask

   task automatic t_pin_mode();
      bit aa, da;
      logic [7:0] rd;
      pin_mode = 1'b1;
      vid_hi = 2'b10; sda_m = 1'b0; scl_m = 1'b1;
      check_out("R5 pins 1001", 9, 1, 1300);
      vid_hi = 2'b01; sda_m = 1'b1; scl_m = 1'b0;
      check_out("R5 pins 0110", 6, 1, 1150);
      scl_m = 1'b1;
      wait_clk(10);
      do_write(7'h0C, 8'h3F, aa, da);
      check("R5 no addr ack", int'(aa), 1);
      check("R5 no data ack", int'(da), 1);
      check("R5 never drives", int'(oe_in_pin), 0);
      check_out("R5 pins 0111", 7, 1, 1200);
      pin_mode = 1'b0;
      vid_hi = 2'b00;
      wait_clk(10);
      check_out("R5 register kept", 11, 1, 1400);
      do_read(aa, rd);
      check("R5 read back", int'(rd), 8'h1B);
   endtask

   initial begin
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      pin_mode = 1'b0; reg_en = 1'b1; vid_hi = 2'b00;
      wait_clk(10);
      rst_n = 1'b1;
      wait_clk(10);
      t_reset();
      half = 125;
      t_write_read("R9 fast", 8'h2A, 10, 2);
      t_write_read("R2 upper bits", 8'hC7, 7, 0);
      t_write_read("R4 top code", 8'h0F, 15, 0);
      t_write_read("R4 bottom code", 8'h30, 0, 3);
      t_mismatch();
      t_abort();
      t_write_read("R2 setup", 8'h12, 2, 1);
      t_extra_byte();
      t_disable();
      t_pin_mode();
      half = 500;
      t_write_read("R9 standard", 8'h25, 5, 2);
      summary();
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule